// File: doc/BRIEF.md
# SD Host Command Issue Unit

This block is the register front end that software uses to send commands to an SD card. It holds a command word, a 32-bit argument, a status word, a configuration word and four 32-bit response words. All of them sit behind a small memory-mapped port. Writing the command word with its start bit set launches a command on a simplified card-side port. That port is a one-cycle request carrying the command index and argument. Some time later it answers with a response-valid pulse, an error flag, a byte count and sixteen response bytes.

When the answer arrives, the block checks the byte count against what the command asked for. On success it unpacks the bytes into the response words as big-endian words. It then sets the fail and timeout flags or the busy-done flag, and drives a single interrupt line from the status word. Serial line timing, CRC, clock division and the data path live elsewhere. The timeout and divider offsets accept writes and discard them.

Top module: `sd_cmd_issue`

## Requirements
- R1: After reset, every register reads 0, the request output is low and the interrupt is low.
- R2: A write to offset 0x00 with bit 15 set, made while no command is pending, raises the request output for exactly one cycle, starting on the cycle after the write. The request carries bits 5:0 of the written word as the index and the argument register (offset 0x04) as the argument.
- R3: While a command is pending, offset 0x00 reads back the written word with bit 15 forced to 1. Once the answer has been taken, bit 15 reads 0 and the other written bits are kept.
- R4: While a command is pending, writes to offsets 0x00 and 0x04 have no effect. A response-valid pulse that arrives while no command is pending changes nothing.
- R5: A command fails when the card reports an error. When bit 10 (no response) of the command is clear, it also fails if the byte count is 0, if the count is 4 while bit 9 (long response) is set, or if the count is neither 4 nor 16. A failure sets bit 14 of the command word and status bit 6, and leaves the response words unchanged.
- R6: A successful 4-byte answer loads response word 0 (offset 0x10) with bytes 0..3 as a big-endian word (byte 0 in bits 31:24) and clears response words 1..3 (offsets 0x14, 0x18, 0x1C).
- R7: A successful 16-byte answer loads word 0 from bytes 12..15, word 1 from bytes 8..11, word 2 from bytes 4..7 and word 3 from bytes 0..3, each as a big-endian word.
- R8: A command with bit 10 set succeeds for any byte count unless the card reports an error, and it leaves the response words unchanged.
- R9: A successful command with bit 11 (busy wait) set raises status bit 10 only if configuration bit 10 (offset 0x38) is set. A failed command never raises it.
- R10: A write to the status register (offset 0x20) clears exactly the bits written as 1.
- R11: The interrupt output is high exactly when any of status bits 10, 9 or 8 is set.
- R12: Writes to offsets 0x08 and 0x0C are discarded. Reads of those offsets, and of any offset not listed above, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| card_req_valid | output | 1 | One-cycle command request |
| card_req_index | output | 6 | Command index |
| card_req_arg | output | 32 | Command argument |
| card_rsp_valid | input | 1 | Answer is present this cycle |
| card_rsp_err | input | 1 | Card-side failure |
| card_rsp_len | input | 5 | Number of valid response bytes |
| card_rsp_bytes | input | 128 | Response bytes, byte i in bits 8i+7:8i |
| irq | output | 1 | Interrupt |

## Verification
The assertions check several properties on every cycle. The request is a single-cycle pulse. The command word holds still while the block waits for an answer. The response words change only on the cycle an answer is accepted. A successful long answer always carries exactly 16 bytes. Status bit 6 rises together with the fail flag, and the busy flag only rises while its enable is set. Only the bench's scenarios can show the byte placement of short and long answers, each failure case of the length check, write-one-to-clear on status, and the interrupt following the status bits. They also cover ignored writes while a command is pending and the address map.

// File: rtl/sdci_pkg.sv
package sdci_pkg;
  localparam int unsigned ADDR_W    = 8;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned CMD_W     = 16;
  localparam int unsigned IDX_W     = 6;
  localparam int unsigned ST_W      = 11;
  localparam int unsigned CFG_W     = 11;
  localparam int unsigned RSP_WORDS = 4;
  localparam int unsigned RSP_BYTES = RSP_WORDS * 4;
  localparam int unsigned LEN_W     = $clog2(RSP_BYTES + 1);

  localparam logic [ADDR_W-1:0] OFF_CMD  = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_ARG  = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_RSP0 = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_RSP1 = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_RSP2 = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_RSP3 = 8'h1C;
  localparam logic [ADDR_W-1:0] OFF_STAT = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_CFG  = 8'h38;

  localparam int unsigned CB_START = 15;
  localparam int unsigned CB_FAIL  = 14;
  localparam int unsigned CB_BUSYW = 11;
  localparam int unsigned CB_NORSP = 10;
  localparam int unsigned CB_LONG  = 9;
  localparam int unsigned SB_BUSY  = 10;
  localparam int unsigned SB_CMDTO = 6;
  localparam int unsigned FB_BUSYEN = 10;

  typedef enum logic [1:0] {SQ_IDLE, SQ_ISSUE, SQ_WAIT} seq_state_e;
endpackage

// File: rtl/sdci_rsp_check.sv
module sdci_rsp_check
  import sdci_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           chk_en,
  input  logic                           card_err,
  input  logic [LEN_W-1:0]               len,
  input  logic                           no_rsp,
  input  logic                           long_rsp,
  input  logic [RSP_BYTES*8-1:0]         bytes_in,
  output logic                           fail,
  output logic [RSP_WORDS-1:0][DATA_W-1:0] words
);
  localparam logic [LEN_W-1:0] LEN_SHORT = LEN_W'(4);
  localparam logic [LEN_W-1:0] LEN_LONG  = LEN_W'(RSP_BYTES);

  logic bad_len;

  always_comb begin
    bad_len = (len == '0) ||
              (len == LEN_SHORT && long_rsp) ||
              (len != LEN_SHORT && len != LEN_LONG);
    fail = card_err || (!no_rsp && bad_len);
  end

  for (genvar w = 0; w < RSP_WORDS; w++) begin : g_word
    localparam int unsigned LBASE = (RSP_WORDS - 1 - w) * 4;
    logic [DATA_W-1:0] long_w;
    logic [DATA_W-1:0] short_w;
    for (genvar k = 0; k < 4; k++) begin : g_byte
      assign long_w[DATA_W-1-8*k -: 8] = bytes_in[8*(LBASE+k) +: 8];
      if (w == 0) begin : g_s0
        assign short_w[DATA_W-1-8*k -: 8] = bytes_in[8*k +: 8];
      end else begin : g_sz
        assign short_w[DATA_W-1-8*k -: 8] = 8'h00;
      end
    end
    assign words[w] = (len == LEN_LONG) ? long_w : short_w;
  end

  // R7: a long request accepted without failure must carry the full length
  p_long_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && !fail && !no_rsp && long_rsp) |-> (len == LEN_LONG));
endmodule

// File: rtl/sdci_seq.sv
module sdci_seq
  import sdci_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic rsp_valid,
  output logic req_valid,
  output logic idle,
  output logic done
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SQ_IDLE:  if (start) state_d = SQ_ISSUE;
      SQ_ISSUE: state_d = SQ_WAIT;
      SQ_WAIT:  if (rsp_valid) state_d = SQ_IDLE;
      default:  state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SQ_IDLE;
    else        state_q <= state_d;
  end

  assign req_valid = (state_q == SQ_ISSUE);
  assign idle      = (state_q == SQ_IDLE);
  assign done      = (state_q == SQ_WAIT) && rsp_valid;

  // R2: request is a single-cycle pulse
  p_req_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid);
endmodule

// File: rtl/sd_cmd_issue.sv
module sd_cmd_issue
  import sdci_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic                    bus_wr,
  input  logic [DATA_W-1:0]       bus_wdata,
  output logic [DATA_W-1:0]       bus_rdata,
  output logic                    card_req_valid,
  output logic [IDX_W-1:0]        card_req_index,
  output logic [DATA_W-1:0]       card_req_arg,
  input  logic                    card_rsp_valid,
  input  logic                    card_rsp_err,
  input  logic [LEN_W-1:0]        card_rsp_len,
  input  logic [RSP_BYTES*8-1:0]  card_rsp_bytes,
  output logic                    irq
);
  logic [CMD_W-1:0]  cmd_q, cmd_d;
  logic [DATA_W-1:0] arg_q, arg_d;
  logic [ST_W-1:0]   stat_q, stat_d;
  logic [CFG_W-1:0]  cfg_q, cfg_d;
  logic [RSP_WORDS-1:0][DATA_W-1:0] rsp_q, rsp_d;
  logic [RSP_WORDS-1:0][DATA_W-1:0] rsp_words;

  logic seq_idle, seq_done, chk_fail;
  logic wr_cmd, wr_arg, wr_stat, wr_cfg, start;

  assign wr_cmd  = bus_wr && (bus_addr == OFF_CMD) && seq_idle;
  assign wr_arg  = bus_wr && (bus_addr == OFF_ARG) && seq_idle;
  assign wr_stat = bus_wr && (bus_addr == OFF_STAT);
  assign wr_cfg  = bus_wr && (bus_addr == OFF_CFG);
  assign start   = wr_cmd && bus_wdata[CB_START];

  sdci_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .rsp_valid (card_rsp_valid),
    .req_valid (card_req_valid),
    .idle      (seq_idle),
    .done      (seq_done)
  );

  sdci_rsp_check u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .chk_en   (seq_done),
    .card_err (card_rsp_err),
    .len      (card_rsp_len),
    .no_rsp   (cmd_q[CB_NORSP]),
    .long_rsp (cmd_q[CB_LONG]),
    .bytes_in (card_rsp_bytes),
    .fail     (chk_fail),
    .words    (rsp_words)
  );

  always_comb begin
    cmd_d  = cmd_q;
    arg_d  = arg_q;
    stat_d = stat_q;
    cfg_d  = cfg_q;
    rsp_d  = rsp_q;
    if (wr_cmd) begin
      cmd_d = bus_wdata[CMD_W-1:0];
      cmd_d[CB_START] = 1'b0;
    end
    if (wr_arg) arg_d = bus_wdata;
    if (wr_cfg) cfg_d = bus_wdata[CFG_W-1:0];
    if (wr_stat) stat_d = stat_q & ~bus_wdata[ST_W-1:0];
    if (seq_done) begin
      if (chk_fail) begin
        cmd_d[CB_FAIL]  = 1'b1;
        stat_d[SB_CMDTO] = 1'b1;
      end else begin
        if (!cmd_q[CB_NORSP]) rsp_d = rsp_words;
        if (cmd_q[CB_BUSYW] && cfg_q[FB_BUSYEN]) stat_d[SB_BUSY] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      arg_q  <= '0;
      stat_q <= '0;
      cfg_q  <= '0;
      rsp_q  <= '0;
    end else begin
      cmd_q  <= cmd_d;
      arg_q  <= arg_d;
      stat_q <= stat_d;
      cfg_q  <= cfg_d;
      rsp_q  <= rsp_d;
    end
  end

  assign card_req_index = cmd_q[IDX_W-1:0];
  assign card_req_arg   = arg_q;
  assign irq            = |stat_q[10:8];

  always_comb begin
    unique case (bus_addr)
      OFF_CMD:  bus_rdata = DATA_W'({!seq_idle, cmd_q[CMD_W-2:0]});
      OFF_ARG:  bus_rdata = arg_q;
      OFF_RSP0: bus_rdata = rsp_q[0];
      OFF_RSP1: bus_rdata = rsp_q[1];
      OFF_RSP2: bus_rdata = rsp_q[2];
      OFF_RSP3: bus_rdata = rsp_q[3];
      OFF_STAT: bus_rdata = DATA_W'(stat_q);
      OFF_CFG:  bus_rdata = DATA_W'(cfg_q);
      default:  bus_rdata = '0;
    endcase
  end

  // R4: command word is frozen while waiting for an answer
  p_cmd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_idle && !seq_done) |=> $stable(cmd_q));
  // R4: response words only move when an answer is accepted
  p_rsp_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_done |=> $stable(rsp_q));
  // R5: fail flag and timeout status rise together
  p_fail_to_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_q[CB_FAIL]) |-> stat_q[SB_CMDTO]);
  // R9: busy status can only rise with its enable set
  p_busy_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[SB_BUSY]) |-> $past(cfg_q[FB_BUSYEN]));
endmodule

// File: tb/sd_cmd_issue_test.sv
module sd_cmd_issue_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   bus_addr = '0;
  logic         bus_wr = 1'b0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic         card_req_valid;
  logic [5:0]   card_req_index;
  logic [31:0]  card_req_arg;
  logic         card_rsp_valid = 1'b0;
  logic         card_rsp_err = 1'b0;
  logic [4:0]   card_rsp_len = '0;
  logic [127:0] card_rsp_bytes = '0;
  logic         irq;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  sd_cmd_issue uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic answer(input logic [4:0] len, input logic err, input logic [127:0] b);
    @(negedge clk);
    card_rsp_valid = 1'b1; card_rsp_len = len; card_rsp_err = err; card_rsp_bytes = b;
    @(negedge clk);
    card_rsp_valid = 1'b0; card_rsp_err = 1'b0;
  endtask

  function automatic logic [31:0] be(input logic [127:0] b, input int base);
    return {b[8*base +: 8], b[8*(base+1) +: 8], b[8*(base+2) +: 8], b[8*(base+3) +: 8]};
  endfunction

  function automatic logic [127:0] pat(input int seed);
    logic [127:0] r;
    for (int i = 0; i < 16; i++) r[8*i +: 8] = 8'(seed + 7*i);
    return r;
  endfunction

  task automatic run_cmd(input logic [15:0] c, input logic [4:0] len, input logic err,
                         input logic [127:0] b);
    wr(8'h00, {16'h0, c});
    answer(len, err, b);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 irq", {31'h0, irq}, 0);
    chk("R1 req", {31'h0, card_req_valid}, 0);
    rd(8'h00, v); chk("R1 cmd", v, 0);
    rd(8'h04, v); chk("R1 arg", v, 0);
    rd(8'h20, v); chk("R1 status", v, 0);
    rd(8'h38, v); chk("R1 cfg", v, 0);
    rd(8'h1C, v); chk("R1 rsp3", v, 0);
  endtask

  task automatic t_long();
    logic [31:0] v;
    logic [127:0] b = pat(8'h31);
    wr(8'h04, 32'hCAFE_0102);
    wr(8'h00, 32'h0000_8202);
    chk("R2 req high", {31'h0, card_req_valid}, 1);
    chk("R2 index", {26'h0, card_req_index}, 2);
    chk("R2 arg", card_req_arg, 32'hCAFE_0102);
    rd(8'h00, v); chk("R3 pending readback", v, 32'h0000_8202);
    @(negedge clk);
    chk("R2 req single cycle", {31'h0, card_req_valid}, 0);
    wr(8'h00, 32'h0000_8005);
    wr(8'h04, 32'h1111_1111);
    rd(8'h00, v); chk("R4 cmd write ignored", v, 32'h0000_8202);
    rd(8'h04, v); chk("R4 arg write ignored", v, 32'hCAFE_0102);
    answer(5'd16, 1'b0, b);
    rd(8'h00, v); chk("R3 start cleared", v, 32'h0000_0202);
    rd(8'h10, v); chk("R7 word0", v, be(b, 12));
    rd(8'h14, v); chk("R7 word1", v, be(b, 8));
    rd(8'h18, v); chk("R7 word2", v, be(b, 4));
    rd(8'h1C, v); chk("R7 word3", v, be(b, 0));
    rd(8'h20, v); chk("R5 no fail on good long", v, 0);
  endtask

  task automatic t_short();
    logic [31:0] v;
    logic [127:0] b = pat(8'h90);
    run_cmd(16'h8011, 5'd4, 1'b0, b);
    rd(8'h10, v); chk("R6 word0", v, be(b, 0));
    rd(8'h14, v); chk("R6 word1 zero", v, 0);
    rd(8'h1C, v); chk("R6 word3 zero", v, 0);
    rd(8'h00, v); chk("R6 cmd no fail", v, 32'h0000_0011);
  endtask

  task automatic t_fail(input logic [15:0] c, input logic [4:0] len, input logic err,
                        input string tag);
    logic [31:0] v, r0;
    rd(8'h10, r0);
    run_cmd(c, len, err, pat(8'h55));
    rd(8'h00, v); chk({"R5 fail flag ", tag}, v, {16'h0, c & 16'h7FFF | 16'h4000});
    rd(8'h20, v); chk({"R5 timeout status ", tag}, v, 32'h40);
    rd(8'h10, v); chk({"R5 rsp unchanged ", tag}, v, r0);
    wr(8'h20, 32'hFFFF_FFFF);
  endtask

  task automatic t_noresp();
    logic [31:0] v, r0;
    rd(8'h10, r0);
    run_cmd(16'h8400, 5'd0, 1'b0, pat(8'h01));
    rd(8'h00, v); chk("R8 no fail", v, 32'h0000_0400);
    rd(8'h20, v); chk("R8 status clean", v, 0);
    rd(8'h10, v); chk("R8 rsp unchanged", v, r0);
  endtask

  task automatic t_busy();
    logic [31:0] v;
    run_cmd(16'h8C00, 5'd0, 1'b0, '0);
    rd(8'h20, v); chk("R9 busy without enable", v, 0);
    wr(8'h38, 32'h400);
    rd(8'h38, v); chk("R12 cfg readback", v, 32'h400);
    run_cmd(16'h8C00, 5'd0, 1'b1, '0);
    rd(8'h20, v); chk("R9 busy not on fail", v, 32'h40);
    chk("R11 irq low on timeout only", {31'h0, irq}, 0);
    wr(8'h20, 32'h40);
    run_cmd(16'h8C00, 5'd3, 1'b0, '0);
    rd(8'h20, v); chk("R9 busy set", v, 32'h400);
    chk("R11 irq high", {31'h0, irq}, 1);
    wr(8'h20, 32'h40);
    rd(8'h20, v); chk("R10 other bit kept", v, 32'h400);
    chk("R11 irq still high", {31'h0, irq}, 1);
    wr(8'h20, 32'h400);
    rd(8'h20, v); chk("R10 bit cleared", v, 0);
    chk("R11 irq low", {31'h0, irq}, 0);
  endtask

  task automatic t_idle_rsp();
    logic [31:0] v, r0;
    rd(8'h10, r0);
    answer(5'd16, 1'b1, pat(8'hE0));
    rd(8'h10, v); chk("R4 idle answer ignored rsp", v, r0);
    rd(8'h20, v); chk("R4 idle answer ignored status", v, 0);
  endtask

  task automatic t_map();
    logic [31:0] v;
    wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h0C, 32'h0000_07FF);
    rd(8'h08, v); chk("R12 timeout offset reads 0", v, 0);
    rd(8'h0C, v); chk("R12 divider offset reads 0", v, 0);
    rd(8'h24, v); chk("R12 unknown offset reads 0", v, 0);
    rd(8'h04, v); chk("R12 arg unaffected", v, 32'hCAFE_0102);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_long();
    t_short();
    t_fail(16'h8202, 5'd4, 1'b0, "long got 4");
    t_fail(16'h8003, 5'd0, 1'b0, "len 0");
    t_fail(16'h8004, 5'd8, 1'b0, "len 8");
    t_fail(16'h8005, 5'd4, 1'b1, "card err");
    t_noresp();
    t_busy();
    t_idle_rsp();
    t_map();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule